// File: doc/BRIEF.md
# Peripheral Command Channel Engine

This block is a memory-mapped command channel. A processor uses it to run one read or write transaction at a time, of 1 to 8 bytes, against a peripheral that sits behind a power-management serial bus. Software stores the outgoing payload in two data words. It then writes a single command word that packs the opcode, the slave id, the register address and the byte count minus one. Finally it polls a status word until the done bit appears.

Before anything reaches the bus, the engine checks access rights. A peripheral is named by its id, which is the slave id shifted left by eight, OR-ed with the high byte of the register address. A small ownership table, loaded through a separate configuration port, records a 3-bit owner for each listed peripheral. Reads are always allowed. A data write goes out only when the recorded owner equals the execution-environment id of the channel.

Allowed requests are handed to a plain request/acknowledge back-end. That back-end answers with read data, with an error, or not at all; a programmable cycle limit turns silence into a dropped transaction. Serial encoding and the physical layer lie outside this block.

Top module: `pcc_engine`

## Requirements
- R1: After reset the status word, both read-data words and both write-data words read 0, `be_req` is low, and the config word reads 0x0000_0010 (environment id 0, cycle limit 16).
- R2: A write to offset 0x00 while idle starts a transaction. `be_req` rises on the next cycle. The back-end sees the following command fields: opcode from bits 31:27, slave id from bits 23:20, address from bits 19:4, and byte count minus one from bits 2:0. `be_wdata` carries {word at 0x14, word at 0x10}, with byte 0 in bits 7:0. The fields stay stable while the request waits.
- R3: A command write clears the status word (offset 0x08), and the status reads 0 for as long as the request is outstanding.
- R4: When a read (opcode 1, 13 or 15) is acknowledged without error, the status becomes 0x1. Bytes 0 to 3 of the response land in the word at 0x18, with byte 0 in the low bits, and bytes 4 to 7 land in the word at 0x1C. Bytes above the byte count read as zero.
- R5: The write opcodes are 0, 2, 14 and 16. A write whose peripheral id has no valid table entry, or whose entry's owner differs from the environment id (config bits 18:16), completes on the next cycle with status 0x5 (done with denied) and raises no request. Reads to the same peripheral are still forwarded.
- R6: An acknowledge with `be_err` high ends the transaction with status 0x3 (done with failure). An error bit is never set without done, and at most one error bit is set at a time.
- R7: If no acknowledge arrives, the request stays high for exactly the cycle limit in config bits 15:0 (0 means 65536), then drops, and the status becomes 0x9 (done with dropped).
- R8: While a request is outstanding, register writes to every offset, the command included, are ignored.
- R9: The non-data opcodes 3 to 6 are forwarded with no ownership check. Any other opcode outside the listed read, write and non-data opcodes completes on the next cycle with status 0x3 and raises no request.
- R10: The configuration port writes one ownership table entry per cycle: an index, a 12-bit peripheral id, a 3-bit owner and a valid bit. A later write to the same index replaces the entry, and a cleared valid bit removes it from lookups. When two valid entries match, the lower index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| own_we | input | 1 | Ownership table entry write strobe |
| own_idx | input | 4 | Ownership table entry index |
| own_pid | input | 12 | Peripheral id stored in the entry |
| own_owner | input | 3 | Owner stored in the entry |
| own_valid | input | 1 | Valid bit stored in the entry |
| be_req | output | 1 | Back-end request, held until acknowledge or cycle limit |
| be_opcode | output | 5 | Opcode of the request |
| be_sid | output | 4 | Slave id of the request |
| be_addr | output | 16 | Register address of the request |
| be_bcm1 | output | 3 | Byte count minus one |
| be_wdata | output | 64 | Write payload, byte 0 in bits 7:0 |
| be_ack | input | 1 | Back-end acknowledge |
| be_err | input | 1 | Back-end error, valid with `be_ack` |
| be_rdata | input | 64 | Back-end read data, valid with `be_ack` |

## Verification
The bench aims at the permission boundary from three directions. It issues writes from a mismatched owner, writes to a peripheral with no entry, and reads to a peripheral the channel does not own. A design that compared the wrong id bits, or checked reads as well, would wrongly forward or deny one of them. It runs partial byte counts of 3 and 5 bytes, where leaving stale upper bytes or splitting the words at the wrong point shows in the read-data words. It stalls the back-end to probe the exact cycle limit, and it issues command and data writes during a busy transaction. It replaces and invalidates table entries and checks that a denied status is cleared by the next command.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int REG_ADDR_W = 5;
    localparam int WORD_W     = 32;
    localparam int OPC_W      = 5;
    localparam int SID_W      = 4;
    localparam int RADDR_W    = 16;
    localparam int BC_W       = 3;
    localparam int PID_W      = SID_W + 8;
    localparam int OWN_W      = 3;
    localparam int TLIM_W     = 16;
    localparam int ST_W       = 4;

    // register byte offsets
    localparam logic [REG_ADDR_W-1:0] OFF_CMD = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFF_CFG = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFF_STS = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFF_WD0 = 5'h10;
    localparam logic [REG_ADDR_W-1:0] OFF_WD1 = 5'h14;
    localparam logic [REG_ADDR_W-1:0] OFF_RD0 = 5'h18;
    localparam logic [REG_ADDR_W-1:0] OFF_RD1 = 5'h1C;

    // status encodings
    localparam logic [ST_W-1:0] ST_DONE = 4'b0001;
    localparam logic [ST_W-1:0] ST_FAIL = 4'b0010;
    localparam logic [ST_W-1:0] ST_DENY = 4'b0100;
    localparam logic [ST_W-1:0] ST_DROP = 4'b1000;

    // opcodes
    localparam logic [OPC_W-1:0] OP_XLWR  = 5'd0;
    localparam logic [OPC_W-1:0] OP_XLRD  = 5'd1;
    localparam logic [OPC_W-1:0] OP_XWR   = 5'd2;
    localparam logic [OPC_W-1:0] OP_RST   = 5'd3;
    localparam logic [OPC_W-1:0] OP_SLP   = 5'd4;
    localparam logic [OPC_W-1:0] OP_SHDN  = 5'd5;
    localparam logic [OPC_W-1:0] OP_WAKE  = 5'd6;
    localparam logic [OPC_W-1:0] OP_XRD   = 5'd13;
    localparam logic [OPC_W-1:0] OP_WR    = 5'd14;
    localparam logic [OPC_W-1:0] OP_RD    = 5'd15;
    localparam logic [OPC_W-1:0] OP_ZWR   = 5'd16;

    typedef enum logic [1:0] {
        CLS_READ   = 2'd0,
        CLS_WRITE  = 2'd1,
        CLS_NODATA = 2'd2,
        CLS_BAD    = 2'd3
    } cmd_cls_e;

endpackage

// File: rtl/pcc_cmd_decode.sv
module pcc_cmd_decode
    import pcc_pkg::*;
(
    input  logic [WORD_W-1:0]  cmd_word,
    output logic [OPC_W-1:0]   opcode,
    output logic [SID_W-1:0]   sid,
    output logic [RADDR_W-1:0] raddr,
    output logic [BC_W-1:0]    bcm1,
    output logic [PID_W-1:0]   pid,
    output cmd_cls_e           cls
);
    logic unused_bits;

    assign opcode      = cmd_word[31:27];
    assign sid         = cmd_word[23:20];
    assign raddr       = cmd_word[19:4];
    assign bcm1        = cmd_word[2:0];
    assign pid         = {sid, raddr[RADDR_W-1:8]};
    assign unused_bits = ^{cmd_word[26:24], cmd_word[3]};

    always_comb begin
        case (opcode)
            OP_XLRD, OP_XRD, OP_RD:          cls = CLS_READ;
            OP_XLWR, OP_XWR, OP_WR, OP_ZWR:  cls = CLS_WRITE;
            OP_RST, OP_SLP, OP_SHDN, OP_WAKE: cls = CLS_NODATA;
            default:                         cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/pcc_own_table.sv
module pcc_own_table #(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 12,
    parameter int OWN_W   = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [PID_W-1:0] cfg_pid,
    input  logic [OWN_W-1:0] cfg_owner,
    input  logic             cfg_valid,
    input  logic [PID_W-1:0] look_pid,
    output logic             look_hit,
    output logic [OWN_W-1:0] look_owner
);
    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        logic [OWN_W-1:0] owner;
    } ent_t;

    ent_t [ENTRIES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (cfg_we && (32'(cfg_idx) < ENTRIES)) begin
            tab_d[cfg_idx].vld   = cfg_valid;
            tab_d[cfg_idx].pid   = cfg_pid;
            tab_d[cfg_idx].owner = cfg_owner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    // lowest matching index wins: scan downward, last assignment sticks
    always_comb begin
        look_hit   = 1'b0;
        look_owner = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tab_q[i].vld && (tab_q[i].pid == look_pid)) begin
                look_hit   = 1'b1;
                look_owner = tab_q[i].owner;
            end
        end
    end
endmodule

// File: rtl/pcc_byte_keep.sv
module pcc_byte_keep #(
    parameter int NBYTES = 8,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [SEL_W-1:0]    last_idx,
    input  logic [8*NBYTES-1:0] din,
    output logic [8*NBYTES-1:0] dout
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign dout[8*g +: 8] = (SEL_W'(g) <= last_idx) ? din[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/pcc_engine.sv
module pcc_engine
    import pcc_pkg::*;
#(
    parameter int OWN_ENTRIES = 16,
    parameter int TLIM_RST    = 16,
    localparam int OWN_IDX_W  = (OWN_ENTRIES > 1) ? $clog2(OWN_ENTRIES) : 1,
    localparam int PAY_W      = 2 * WORD_W,
    localparam int NBYTES     = PAY_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic                  own_we,
    input  logic [OWN_IDX_W-1:0]  own_idx,
    input  logic [PID_W-1:0]      own_pid,
    input  logic [OWN_W-1:0]      own_owner,
    input  logic                  own_valid,
    output logic                  be_req,
    output logic [OPC_W-1:0]      be_opcode,
    output logic [SID_W-1:0]      be_sid,
    output logic [RADDR_W-1:0]    be_addr,
    output logic [BC_W-1:0]       be_bcm1,
    output logic [PAY_W-1:0]      be_wdata,
    input  logic                  be_ack,
    input  logic                  be_err,
    input  logic [PAY_W-1:0]      be_rdata
);
    typedef struct packed {
        logic                busy;
        logic [TLIM_W-1:0]   cnt;
        logic [ST_W-1:0]     status;
        logic [OPC_W-1:0]    opc;
        logic [SID_W-1:0]    sid;
        logic [RADDR_W-1:0]  raddr;
        logic [BC_W-1:0]     bcm1;
        cmd_cls_e            cls;
        logic [WORD_W-1:0]   wd0;
        logic [WORD_W-1:0]   wd1;
        logic [WORD_W-1:0]   rd0;
        logic [WORD_W-1:0]   rd1;
        logic [OWN_W-1:0]    env;
        logic [TLIM_W-1:0]   tlim;
    } st_t;

    st_t st_d, st_q;

    // decode of the incoming command word
    logic [OPC_W-1:0]   n_opc;
    logic [SID_W-1:0]   n_sid;
    logic [RADDR_W-1:0] n_raddr;
    logic [BC_W-1:0]    n_bcm1;
    logic [PID_W-1:0]   n_pid;
    cmd_cls_e           n_cls;

    logic               own_hit;
    logic [OWN_W-1:0]   own_of_pid;
    logic [PAY_W-1:0]   rsp_kept;
    logic [ST_W-1:0]    status_w;
    logic [TLIM_W-1:0]  tlim_w;

    pcc_cmd_decode u_dec (
        .cmd_word (reg_wdata),
        .opcode   (n_opc),
        .sid      (n_sid),
        .raddr    (n_raddr),
        .bcm1     (n_bcm1),
        .pid      (n_pid),
        .cls      (n_cls)
    );

    pcc_own_table #(
        .ENTRIES (OWN_ENTRIES),
        .PID_W   (PID_W),
        .OWN_W   (OWN_W)
    ) u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (own_we),
        .cfg_idx    (own_idx),
        .cfg_pid    (own_pid),
        .cfg_owner  (own_owner),
        .cfg_valid  (own_valid),
        .look_pid   (n_pid),
        .look_hit   (own_hit),
        .look_owner (own_of_pid)
    );

    pcc_byte_keep #(
        .NBYTES (NBYTES)
    ) u_keep (
        .last_idx (st_q.bcm1),
        .din      (be_rdata),
        .dout     (rsp_kept)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (be_ack) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                if (be_err) begin
                    st_d.status = ST_DONE | ST_FAIL;
                end else begin
                    st_d.status = ST_DONE;
                    if (st_q.cls == CLS_READ) begin
                        st_d.rd0 = rsp_kept[WORD_W-1:0];
                        st_d.rd1 = rsp_kept[PAY_W-1:WORD_W];
                    end
                end
            end else if (st_q.cnt == st_q.tlim - 1'b1) begin
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
                st_d.status = ST_DONE | ST_DROP;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (reg_we) begin
            case (reg_addr)
                OFF_CMD: begin
                    st_d.opc    = n_opc;
                    st_d.sid    = n_sid;
                    st_d.raddr  = n_raddr;
                    st_d.bcm1   = n_bcm1;
                    st_d.cls    = n_cls;
                    st_d.cnt    = '0;
                    st_d.status = '0;
                    case (n_cls)
                        CLS_BAD:   st_d.status = ST_DONE | ST_FAIL;
                        CLS_WRITE: begin
                            if (!own_hit || (own_of_pid != st_q.env))
                                st_d.status = ST_DONE | ST_DENY;
                            else
                                st_d.busy = 1'b1;
                        end
                        default:   st_d.busy = 1'b1;
                    endcase
                end
                OFF_CFG: begin
                    st_d.tlim = reg_wdata[TLIM_W-1:0];
                    st_d.env  = reg_wdata[TLIM_W +: OWN_W];
                end
                OFF_WD0: st_d.wd0 = reg_wdata;
                OFF_WD1: st_d.wd1 = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cls  <= CLS_READ;
            st_q.tlim <= TLIM_W'(TLIM_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign status_w = st_q.status;
    assign tlim_w   = st_q.tlim;

    always_comb begin
        case (reg_addr)
            OFF_CMD: reg_rdata = {st_q.opc, 3'b000, st_q.sid, st_q.raddr, 1'b0, st_q.bcm1};
            OFF_CFG: reg_rdata = {{(WORD_W-TLIM_W-OWN_W){1'b0}}, st_q.env, st_q.tlim};
            OFF_STS: reg_rdata = {{(WORD_W-ST_W){1'b0}}, st_q.status};
            OFF_WD0: reg_rdata = st_q.wd0;
            OFF_WD1: reg_rdata = st_q.wd1;
            OFF_RD0: reg_rdata = st_q.rd0;
            OFF_RD1: reg_rdata = st_q.rd1;
            default: reg_rdata = '0;
        endcase
    end

    assign be_req    = st_q.busy;
    assign be_opcode = st_q.opc;
    assign be_sid    = st_q.sid;
    assign be_addr   = st_q.raddr;
    assign be_bcm1   = st_q.bcm1;
    assign be_wdata  = {st_q.wd1, st_q.wd0};
endmodule

// File: rtl/pcc_engine_chk.sv
module pcc_engine_chk
    import pcc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  be_req,
    input logic                  be_ack,
    input logic                  be_err,
    input logic [OPC_W-1:0]      be_opcode,
    input logic [RADDR_W-1:0]    be_addr,
    input logic [ST_W-1:0]       status,
    input logic [TLIM_W-1:0]     tlim
);
    logic [TLIM_W:0] run_q;
    logic [TLIM_W:0] lim_eff;

    assign lim_eff = (tlim == '0) ? {1'b1, {TLIM_W{1'b0}}} : {1'b0, tlim};

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (be_req) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R2: request fields hold while waiting
    a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (!be_req || ($stable(be_opcode) && $stable(be_addr))));

    // R2, R8: a request only starts from a command write
    a_r8_req_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_req) |-> $past(reg_we && (reg_addr == OFF_CMD)));

    // R3: status is clear during an outstanding request
    a_r3_status_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (status == '0));

    // R4: clean acknowledge gives done only
    a_r4_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_ack && !be_err) |=> (status == ST_DONE));

    // R5: denied status never coexists with a request
    a_r5_denied_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (status == (ST_DONE | ST_DENY)) |-> !be_req);

    // R6: error acknowledge gives done with failure
    a_r6_err_failure: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_ack && be_err) |=> (status == (ST_DONE | ST_FAIL)));

    // R6: error bits only with done, at most one
    a_r6_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:1] != '0) |-> status[0]);

    a_r6_single_error: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1]));

    // R7: request never outlives the cycle limit
    a_r7_req_window: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (run_q < lim_eff));
endmodule

bind pcc_engine pcc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .be_req    (be_req),
    .be_ack    (be_ack),
    .be_err    (be_err),
    .be_opcode (be_opcode),
    .be_addr   (be_addr),
    .status    (status_w),
    .tlim      (tlim_w)
);

// File: tb/pcc_engine_tb_top.sv
module pcc_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        own_we = 1'b0;
    logic [3:0]  own_idx = '0;
    logic [11:0] own_pid = '0;
    logic [2:0]  own_owner = '0;
    logic        own_valid = 1'b0;
    logic        be_req;
    logic [4:0]  be_opcode;
    logic [3:0]  be_sid;
    logic [15:0] be_addr;
    logic [2:0]  be_bcm1;
    logic [63:0] be_wdata;
    logic        be_ack = 1'b0;
    logic        be_err = 1'b0;
    logic [63:0] be_rdata = '0;

    int n_total = 0;
    int n_fail  = 0;

    // back-end model controls: 0 data, 1 error, 2 silent
    int          bm_mode  = 0;
    int          bm_delay = 0;
    logic [63:0] bm_data  = '0;
    int          wait_cnt = 0;
    int          req_cycles = 0;
    logic [4:0]  cap_opc;
    logic [3:0]  cap_sid;
    logic [15:0] cap_addr;
    logic [2:0]  cap_bcm1;
    logic [63:0] cap_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcc_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .own_we    (own_we),
        .own_idx   (own_idx),
        .own_pid   (own_pid),
        .own_owner (own_owner),
        .own_valid (own_valid),
        .be_req    (be_req),
        .be_opcode (be_opcode),
        .be_sid    (be_sid),
        .be_addr   (be_addr),
        .be_bcm1   (be_bcm1),
        .be_wdata  (be_wdata),
        .be_ack    (be_ack),
        .be_err    (be_err),
        .be_rdata  (be_rdata)
    );

    // back-end responder, acts on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (be_ack) begin
                be_ack   = 1'b0;
                be_err   = 1'b0;
                wait_cnt = 0;
            end else if (be_req) begin
                if (req_cycles == 0) begin
                    cap_opc   = be_opcode;
                    cap_sid   = be_sid;
                    cap_addr  = be_addr;
                    cap_bcm1  = be_bcm1;
                    cap_wdata = be_wdata;
                end
                req_cycles++;
                if (bm_mode != 2) begin
                    if (wait_cnt == bm_delay) begin
                        be_ack   = 1'b1;
                        be_err   = (bm_mode == 1);
                        be_rdata = bm_data;
                    end else begin
                        wait_cnt++;
                    end
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcmd(input logic [4:0] opc, input logic [3:0] sid,
                                          input logic [15:0] addr, input logic [2:0] bcm1);
        return {opc, 3'b000, sid, addr, 1'b0, bcm1};
    endfunction

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic own_load(input logic [3:0] idx, input logic [11:0] pid,
                            input logic [2:0] owner, input logic vld);
        @(negedge clk);
        own_we = 1'b1; own_idx = idx; own_pid = pid; own_owner = owner; own_valid = vld;
        @(negedge clk);
        own_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] env, input logic [15:0] lim);
        reg_write(5'h04, {13'b0, env, lim});
    endtask

    task automatic run_cmd(input logic [31:0] cmd, output logic [31:0] sts);
        req_cycles = 0;
        reg_write(5'h00, cmd);
        for (int i = 0; i < 300; i++) begin
            reg_read(5'h08, sts);
            if (sts[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(5'h08, v); chk("R1", "status", v, 0);
        reg_read(5'h18, v); chk("R1", "rd0", v, 0);
        reg_read(5'h1C, v); chk("R1", "rd1", v, 0);
        reg_read(5'h10, v); chk("R1", "wd0", v, 0);
        reg_read(5'h04, v); chk("R1", "cfg", v, 32'h10);
        chk("R1", "be_req", be_req, 0);
    endtask

    task automatic t_read_partial;
        logic [31:0] v;
        bm_mode = 0; bm_delay = 2; bm_data = 64'h8877_6655_4433_2211;
        run_cmd(mkcmd(5'd15, 4'h5, 16'h1234, 3'd2), v);
        chk("R4", "status 3B read", v, 32'h1);
        chk("R2", "opcode", cap_opc, 15);
        chk("R2", "sid", cap_sid, 5);
        chk("R2", "addr", cap_addr, 16'h1234);
        chk("R2", "bcm1", cap_bcm1, 2);
        reg_read(5'h18, v); chk("R4", "rd0 3B", v, 32'h0033_2211);
        reg_read(5'h1C, v); chk("R4", "rd1 3B", v, 0);
    endtask

    task automatic t_read_full;
        logic [31:0] v;
        bm_mode = 0; bm_delay = 0; bm_data = 64'h8877_6655_4433_2211;
        run_cmd(mkcmd(5'd1, 4'hA, 16'h40FF, 3'd7), v);
        chk("R4", "status 8B read", v, 32'h1);
        reg_read(5'h18, v); chk("R4", "rd0 8B", v, 32'h4433_2211);
        reg_read(5'h1C, v); chk("R4", "rd1 8B", v, 32'h8877_6655);
        bm_data = 64'hF0E0_D0C0_B0A0_9080;
        run_cmd(mkcmd(5'd13, 4'h1, 16'h0200, 3'd4), v);
        reg_read(5'h18, v); chk("R4", "rd0 5B", v, 32'hB0A0_9080);
        reg_read(5'h1C, v); chk("R4", "rd1 5B", v, 32'h0000_00C0);
    endtask

    task automatic t_write_perm;
        logic [31:0] v;
        own_load(4'd0, 12'h312, 3'd2, 1'b1);
        own_load(4'd1, 12'h4AB, 3'd1, 1'b1);
        set_cfg(3'd2, 16'd16);
        reg_write(5'h10, 32'hDDCC_BBAA);
        reg_write(5'h14, 32'h1122_3344);
        bm_mode = 0; bm_delay = 1;
        run_cmd(mkcmd(5'd14, 4'h3, 16'h12C0, 3'd7), v);
        chk("R5", "owned write status", v, 32'h1);
        chk("R2", "wdata", cap_wdata, 64'h1122_3344_DDCC_BBAA);
        run_cmd(mkcmd(5'd0, 4'h4, 16'hAB00, 3'd0), v);
        chk("R5", "foreign write status", v, 32'h5);
        chk("R5", "foreign write no req", req_cycles, 0);
        run_cmd(mkcmd(5'd16, 4'h9, 16'h7700, 3'd0), v);
        chk("R5", "unlisted write status", v, 32'h5);
        run_cmd(mkcmd(5'd15, 4'h4, 16'hAB10, 3'd0), v);
        chk("R5", "foreign read permitted", v, 32'h1);
        chk("R5", "foreign read req", (req_cycles > 0), 1);
    endtask

    task automatic t_error;
        logic [31:0] v;
        bm_mode = 1; bm_delay = 1;
        run_cmd(mkcmd(5'd15, 4'h2, 16'h0010, 3'd0), v);
        chk("R6", "error status", v, 32'h3);
        bm_mode = 0;
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        set_cfg(3'd2, 16'd5);
        bm_mode = 2;
        run_cmd(mkcmd(5'd15, 4'h2, 16'h0010, 3'd0), v);
        chk("R7", "dropped status", v, 32'h9);
        chk("R7", "request cycles", req_cycles, 5);
        bm_mode = 0;
        set_cfg(3'd2, 16'd16);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        bm_mode = 0; bm_delay = 8; bm_data = '0;
        reg_write(5'h10, 32'h0000_00AA);
        req_cycles = 0;
        reg_write(5'h00, mkcmd(5'd15, 4'h6, 16'h5500, 3'd0));
        reg_read(5'h08, v); chk("R3", "status while busy", v, 0);
        reg_write(5'h00, mkcmd(5'd14, 4'h7, 16'h6600, 3'd1));
        reg_write(5'h10, 32'h0000_00BB);
        reg_write(5'h04, {13'b0, 3'd7, 16'd3});
        for (int i = 0; i < 50; i++) begin
            reg_read(5'h08, v);
            if (v[0]) break;
            @(negedge clk);
        end
        chk("R8", "status after busy", v, 32'h1);
        chk("R8", "addr kept", cap_addr, 16'h5500);
        reg_read(5'h00, v); chk("R8", "cmd kept", v, mkcmd(5'd15, 4'h6, 16'h5500, 3'd0));
        reg_read(5'h10, v); chk("R8", "wd0 kept", v, 32'h0000_00AA);
        reg_read(5'h04, v); chk("R8", "cfg kept", v, {13'b0, 3'd2, 16'd16});
        bm_delay = 0;
    endtask

    task automatic t_opcodes;
        logic [31:0] v;
        run_cmd(mkcmd(5'd9, 4'h1, 16'h0000, 3'd0), v);
        chk("R9", "bad opcode status", v, 32'h3);
        chk("R9", "bad opcode no req", req_cycles, 0);
        run_cmd(mkcmd(5'd4, 4'h7, 16'h0000, 3'd0), v);
        chk("R9", "non-data status", v, 32'h1);
        chk("R9", "non-data opcode", cap_opc, 4);
    endtask

    task automatic t_clear_status;
        logic [31:0] v;
        run_cmd(mkcmd(5'd14, 4'h4, 16'hAB00, 3'd0), v);
        chk("R3", "denied before", v, 32'h5);
        bm_delay = 4;
        reg_write(5'h00, mkcmd(5'd15, 4'h1, 16'h0000, 3'd0));
        reg_read(5'h08, v); chk("R3", "cleared by command", v, 0);
        repeat (10) @(negedge clk);
        bm_delay = 0;
    endtask

    task automatic t_table_update;
        logic [31:0] v;
        own_load(4'd0, 12'h312, 3'd5, 1'b1);
        run_cmd(mkcmd(5'd14, 4'h3, 16'h1200, 3'd0), v);
        chk("R10", "replaced owner denies", v, 32'h5);
        own_load(4'd0, 12'h312, 3'd2, 1'b0);
        run_cmd(mkcmd(5'd14, 4'h3, 16'h1200, 3'd0), v);
        chk("R10", "invalid entry denies", v, 32'h5);
        own_load(4'd3, 12'h312, 3'd2, 1'b1);
        run_cmd(mkcmd(5'd14, 4'h3, 16'h1200, 3'd0), v);
        chk("R10", "new entry permits", v, 32'h1);
        own_load(4'd2, 12'h312, 3'd6, 1'b1);
        run_cmd(mkcmd(5'd14, 4'h3, 16'h1200, 3'd0), v);
        chk("R10", "lower index wins", v, 32'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_partial();
        t_read_full();
        t_write_perm();
        t_error();
        t_timeout();
        t_busy_ignore();
        t_opcodes();
        t_clear_status();
        t_table_update();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule